// File: doc/BRIEF.md
# Overlapped LDPC Decode Sequence Controller

This block schedules the two node-update engines of a semi-parallel, quasi-cyclic LDPC decoder whose parity part is upper dual-diagonal. Each clock it can hand one block-row index (L check nodes) to the check-node engine and one block-column index (L variable nodes) to the variable-node engine. Each engine reports completion of a group on its acknowledge line. Because the parity part is upper dual-diagonal, the first parity column depends only on the first block row. So variable-node work can start one cycle after check-node work and then run alongside it. The same fixed order serves every code rate.

A decode starts with a one-cycle initialization. It then repeats iterations, and each iteration passes through a check-only stretch, an overlapped stretch and a variable-only stretch. At the end of every iteration an external parity-check result decides whether the decode stops. A decode that never passes stops at a configured iteration limit and flags failure. The node arithmetic and the message memories sit outside this block.

Top module: `ldpc_ovl_seq`

## Requirements
- R1: Out of reset, busy, dec_done, dec_fail, init_go, cn_go, vn_go and hd_latch are low and iter_used is zero.
- R2: dec_start seen while idle makes init_go and busy high in the next cycle, with init_go high for exactly one cycle. dec_start seen while busy is ignored and changes no output.
- R3: cn_row runs through block rows 0, 1, …, ROWS-1 of each iteration. An index is held on cn_row with cn_go high until cn_ack is seen with it, and the next row follows in the cycle after.
- R4: vn_col is a physical block column, with the information part in columns 0 … COLS-ROWS-1 and the parity part in COLS-ROWS … COLS-1. The issue order is all parity columns in ascending order, then all information columns in ascending order. Each index is held until vn_ack.
- R5: Parity column k (counted from 0 inside the parity part) is issued only once rows 0…k have been acknowledged. Information columns are issued only once all rows are acknowledged. Both engines are driven as soon as these rules allow.
- R6: With both engines always acknowledging, one iteration takes COLS+1 cycles: 1 check-only cycle, ROWS-1 overlapped cycles and COLS-ROWS+1 variable-only cycles. A decode of I iterations keeps busy high for 1+I·(COLS+1) cycles.
- R7: hd_latch is high in exactly the cycles where a variable group is acknowledged (vn_go and vn_ack both high).
- R8: parity_ok is sampled in the cycle of the final variable acknowledge of an iteration. If it is high, the next cycle shows dec_done high, busy low, dec_fail low and iter_used equal to that iteration's number (1-based).
- R9: If the decode does not stop, the next iteration begins in the following cycle at row 0, with no initialization cycle.
- R10: If parity_ok is low at the end of iteration ITER_MAX, the decode ends with dec_done high, dec_fail high and iter_used equal to ITER_MAX.
- R11: dec_done is a one-cycle pulse. dec_fail and iter_used keep their values until the next decode completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dec_start | input | 1 | Request to begin a decode |
| parity_ok | input | 1 | All parity checks satisfied by the current hard decisions |
| cn_go | output | 1 | Check-node engine trigger |
| cn_row | output | $clog2(ROWS) | Block row to update |
| cn_ack | input | 1 | Check-node engine finished the presented row |
| vn_go | output | 1 | Variable-node engine trigger |
| vn_col | output | $clog2(COLS) | Block column to update |
| vn_ack | input | 1 | Variable-node engine finished the presented column |
| hd_latch | output | 1 | Latch the tentative hard decision of the acknowledged column |
| init_go | output | 1 | One-cycle initialization strobe |
| busy | output | 1 | Decode in progress |
| dec_done | output | 1 | Decode finished (one cycle) |
| dec_fail | output | 1 | Last decode hit the iteration limit without passing |
| iter_used | output | $clog2(ITER_MAX+1) | Iterations used by the last decode |

## Verification
Triggers, indices and hd_latch are combinational from registered counters and the acknowledge inputs. They are due in the same cycle as the state that produces them. init_go follows an accepted dec_start by one cycle. dec_done, dec_fail and iter_used follow the final variable acknowledge by one cycle. The bench drives inputs just after the rising edge and samples on the falling edge. It keeps its own row, column and iteration counts, advances them only on the acknowledges it predicts for the coming edge, and compares every output each cycle. It sweeps pass-iteration and stall patterns on a 4×7 block matrix.

// File: rtl/ldpc_seq_pkg.sv
package ldpc_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_INIT,
    ST_RUN
  } seq_state_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_INIT,
    PH_CNU_ONLY,
    PH_OVERLAP,
    PH_VNU_ONLY,
    PH_HOLD
  } seq_phase_e;

  // Physical block column for the ord-th variable group of an iteration:
  // parity part (upper dual-diagonal) first, then the information part.
  function automatic int unsigned vnu_block_col(int unsigned ord,
                                                int unsigned m,
                                                int unsigned n);
    if (ord < m) return (n - m) + ord;
    return ord - m;
  endfunction

  // Number of block rows that must be complete before the ord-th variable
  // group may start: parity column k touches rows k-1 and k only.
  function automatic int unsigned rows_before_vnu(int unsigned ord,
                                                  int unsigned m);
    if (ord < m) return ord + 1;
    return m;
  endfunction

endpackage

// File: rtl/ldpc_seq_row_issuer.sv
module ldpc_seq_row_issuer #(
  parameter  int unsigned ROWS = 12,
  localparam int unsigned RW   = $clog2(ROWS),
  localparam int unsigned RCW  = $clog2(ROWS + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           run,
  input  logic           clr,
  input  logic           eng_ack,
  output logic           trig,
  output logic [RW-1:0]  row,
  output logic [RCW-1:0] rows_done
);

  localparam logic [RCW-1:0] ROWS_V = RCW'(ROWS);

  logic [RCW-1:0] cnt_q;
  logic           fire;

  assign trig      = run && (cnt_q < ROWS_V);
  assign fire      = trig && eng_ack;
  assign row       = cnt_q[RW-1:0];
  assign rows_done = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clr)    cnt_q <= '0;
    else if (fire)   cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/ldpc_seq_col_issuer.sv
module ldpc_seq_col_issuer #(
  parameter  int unsigned ROWS = 12,
  parameter  int unsigned COLS = 24,
  localparam int unsigned CW   = $clog2(COLS),
  localparam int unsigned RCW  = $clog2(ROWS + 1),
  localparam int unsigned CCW  = $clog2(COLS + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           run,
  input  logic           clr,
  input  logic [RCW-1:0] rows_done,
  input  logic           eng_ack,
  output logic           trig,
  output logic [CW-1:0]  col,
  output logic [CCW-1:0] cols_done,
  output logic           last_fire,
  output logic           fire
);

  localparam logic [CCW-1:0] COLS_V = CCW'(COLS);

  logic [CCW-1:0] cnt_q;
  logic [RCW-1:0] need;

  assign need      = RCW'(ldpc_seq_pkg::rows_before_vnu(32'(cnt_q), ROWS));
  assign trig      = run && (cnt_q < COLS_V) && (rows_done >= need);
  assign col       = CW'(ldpc_seq_pkg::vnu_block_col(32'(cnt_q), ROWS, COLS));
  assign fire      = trig && eng_ack;
  assign last_fire = fire && (cnt_q == COLS_V - 1'b1);
  assign cols_done = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clr)    cnt_q <= '0;
    else if (fire)   cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/ldpc_seq_iter_ctrl.sv
module ldpc_seq_iter_ctrl #(
  parameter  int unsigned ITER_MAX = 12,
  localparam int unsigned IW       = $clog2(ITER_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          iter_end,
  input  logic          pass,
  output logic          run,
  output logic          init,
  output logic          clr,
  output logic          busy,
  output logic          done,
  output logic          fail,
  output logic [IW-1:0] iter_used
);

  import ldpc_seq_pkg::*;

  localparam logic [IW-1:0] ITER_MAX_V = IW'(ITER_MAX);

  seq_state_e    st_q;
  logic [IW-1:0] iter_q;
  logic          stop;

  assign run  = (st_q == ST_RUN);
  assign init = (st_q == ST_INIT);
  assign busy = (st_q != ST_IDLE);
  assign clr  = init || (run && iter_end);
  assign stop = run && iter_end && (pass || (iter_q == ITER_MAX_V));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      iter_q    <= '0;
      done      <= 1'b0;
      fail      <= 1'b0;
      iter_used <= '0;
    end else begin
      done <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start) begin
          st_q   <= ST_INIT;
          iter_q <= IW'(1);
        end
        ST_INIT: st_q <= ST_RUN;
        ST_RUN: begin
          if (stop) begin
            st_q      <= ST_IDLE;
            done      <= 1'b1;
            fail      <= !pass;
            iter_used <= iter_q;
          end else if (iter_end) begin
            iter_q <= iter_q + 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ldpc_ovl_seq.sv
module ldpc_ovl_seq #(
  parameter  int unsigned ROWS     = 12,
  parameter  int unsigned COLS     = 24,
  parameter  int unsigned ITER_MAX = 12,
  localparam int unsigned RW       = $clog2(ROWS),
  localparam int unsigned CW       = $clog2(COLS),
  localparam int unsigned IW       = $clog2(ITER_MAX + 1),
  localparam int unsigned RCW      = $clog2(ROWS + 1),
  localparam int unsigned CCW      = $clog2(COLS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dec_start,
  input  logic          parity_ok,
  output logic          cn_go,
  output logic [RW-1:0] cn_row,
  input  logic          cn_ack,
  output logic          vn_go,
  output logic [CW-1:0] vn_col,
  input  logic          vn_ack,
  output logic          hd_latch,
  output logic          init_go,
  output logic          busy,
  output logic          dec_done,
  output logic          dec_fail,
  output logic [IW-1:0] iter_used
);

  import ldpc_seq_pkg::*;

  // Internal events brought out as named wires for the checker.
  logic           run;
  logic           clr;
  logic           iter_end;
  logic [RCW-1:0] rows_done;
  logic [CCW-1:0] cols_done;
  seq_phase_e     phase;

  ldpc_seq_iter_ctrl #(.ITER_MAX(ITER_MAX)) u_iter (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (dec_start),
    .iter_end  (iter_end),
    .pass      (parity_ok),
    .run       (run),
    .init      (init_go),
    .clr       (clr),
    .busy      (busy),
    .done      (dec_done),
    .fail      (dec_fail),
    .iter_used (iter_used)
  );

  ldpc_seq_row_issuer #(.ROWS(ROWS)) u_rows (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .clr       (clr),
    .eng_ack   (cn_ack),
    .trig      (cn_go),
    .row       (cn_row),
    .rows_done (rows_done)
  );

  ldpc_seq_col_issuer #(.ROWS(ROWS), .COLS(COLS)) u_cols (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .clr       (clr),
    .rows_done (rows_done),
    .eng_ack   (vn_ack),
    .trig      (vn_go),
    .col       (vn_col),
    .cols_done (cols_done),
    .last_fire (iter_end),
    .fire      (hd_latch)
  );

  always_comb begin
    if (!busy)        phase = PH_IDLE;
    else if (init_go) phase = PH_INIT;
    else begin
      unique case ({cn_go, vn_go})
        2'b10:   phase = PH_CNU_ONLY;
        2'b11:   phase = PH_OVERLAP;
        2'b01:   phase = PH_VNU_ONLY;
        default: phase = PH_HOLD;
      endcase
    end
  end

endmodule

// File: rtl/ldpc_ovl_seq_chk.sv
module ldpc_ovl_seq_chk #(
  parameter  int unsigned ROWS     = 12,
  parameter  int unsigned COLS     = 24,
  parameter  int unsigned ITER_MAX = 12,
  localparam int unsigned RW       = $clog2(ROWS),
  localparam int unsigned CW       = $clog2(COLS),
  localparam int unsigned IW       = $clog2(ITER_MAX + 1),
  localparam int unsigned RCW      = $clog2(ROWS + 1)
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     dec_start,
  input logic                     parity_ok,
  input logic                     cn_go,
  input logic [RW-1:0]            cn_row,
  input logic                     cn_ack,
  input logic                     vn_go,
  input logic [CW-1:0]            vn_col,
  input logic                     init_go,
  input logic                     busy,
  input logic                     dec_done,
  input logic                     dec_fail,
  input logic [IW-1:0]            iter_used,
  input logic [RCW-1:0]           rows_done,
  input ldpc_seq_pkg::seq_phase_e phase
);

  import ldpc_seq_pkg::*;

  localparam int unsigned H1 = COLS - ROWS;

  // R2
  start_to_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_start && !busy |=> init_go);

  // R2
  init_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_go |=> !init_go && busy);

  // R3
  row_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cn_go && !cn_ack |=> cn_go && $stable(cn_row));

  // R3
  row_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cn_go && cn_ack && (32'(cn_row) != ROWS - 1) |=>
      cn_go && (cn_row == $past(cn_row) + 1'b1));

  // R5
  parity_dep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vn_go && (32'(vn_col) >= H1) |-> 32'(rows_done) > 32'(vn_col) - H1);

  // R5
  info_dep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vn_go && (32'(vn_col) < H1) |-> (32'(rows_done) == ROWS) && !cn_go);

  // R9
  phase_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase == PH_VNU_ONLY |=>
      phase == PH_VNU_ONLY || phase == PH_CNU_ONLY || phase == PH_IDLE);

  // R8
  pass_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_done && !dec_fail |-> $past(parity_ok));

  // R10
  limit_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_done && dec_fail |-> (32'(iter_used) == ITER_MAX) && !$past(parity_ok));

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_done |-> !busy ##1 !dec_done);

endmodule

bind ldpc_ovl_seq ldpc_ovl_seq_chk #(
  .ROWS(ROWS), .COLS(COLS), .ITER_MAX(ITER_MAX)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .dec_start (dec_start),
  .parity_ok (parity_ok),
  .cn_go     (cn_go),
  .cn_row    (cn_row),
  .cn_ack    (cn_ack),
  .vn_go     (vn_go),
  .vn_col    (vn_col),
  .init_go   (init_go),
  .busy      (busy),
  .dec_done  (dec_done),
  .dec_fail  (dec_fail),
  .iter_used (iter_used),
  .rows_done (rows_done),
  .phase     (phase)
);

// File: tb/ldpc_ovl_seq_tb.sv
`timescale 1ns/1ps
module ldpc_ovl_seq_tb;

  localparam int R  = 4;
  localparam int C  = 7;
  localparam int IM = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       dec_start = 1'b0;
  logic       parity_ok = 1'b0;
  logic       cn_ack = 1'b0;
  logic       vn_ack = 1'b0;
  logic       cn_go, vn_go, hd_latch, init_go, busy, dec_done, dec_fail;
  logic [1:0] cn_row;
  logic [2:0] vn_col;
  logic [1:0] iter_used;

  always #4 clk = ~clk;

  ldpc_ovl_seq #(.ROWS(R), .COLS(C), .ITER_MAX(IM)) u_dut (
    .clk(clk), .rst_n(rst_n), .dec_start(dec_start), .parity_ok(parity_ok),
    .cn_go(cn_go), .cn_row(cn_row), .cn_ack(cn_ack),
    .vn_go(vn_go), .vn_col(vn_col), .vn_ack(vn_ack),
    .hd_latch(hd_latch), .init_go(init_go), .busy(busy),
    .dec_done(dec_done), .dec_fail(dec_fail), .iter_used(iter_used)
  );

  int checks = 0, fails = 0;
  bit mon_en = 0;
  int rows_b = 0, cols_b = 0, iter_b = 0, used_b = 0, decodes = 0;
  bit fail_b = 0, init_b = 0, run_b = 0, done_b = 0;
  int pass_at = 99, stall = 0, busy_cyc = 0;
  int n_c = 0, n_b = 0, n_v = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Information columns sit first in H, parity columns last; parity goes first in time.
  function automatic int col_of(int ord);
    int info = C - R;
    if (ord >= R) return ord - R;
    return info + ord;
  endfunction

  function automatic int rows_needed(int ord);
    return (ord < R) ? ord + 1 : R;
  endfunction

  // Input driver: just after each rising edge.
  initial forever begin
    @(posedge clk);
    #1;
    cn_ack    = stall[0] ? (($urandom % 3) != 0) : 1'b1;
    vn_ack    = stall[1] ? (($urandom % 3) != 0) : 1'b1;
    parity_ok = run_b && (iter_b >= pass_at);
  end

  // Monitor and reference model: on the falling edge.
  always @(negedge clk) if (mon_en) begin
    bit ec, ev, hc, hv;
    ec = run_b && (rows_b < R);
    ev = run_b && (cols_b < C) && (rows_b >= rows_needed(cols_b));
    if (init_b || run_b) busy_cyc++;

    chk(cn_go == ec, "R5 cnu trigger", cn_go, ec);
    if (ec) chk(int'(cn_row) == rows_b, "R3 row order", cn_row, rows_b);
    chk(vn_go == ev, "R5 vnu trigger", vn_go, ev);
    if (ev) chk(int'(vn_col) == col_of(cols_b), "R4 column order", vn_col, col_of(cols_b));
    if (vn_go) begin
      if (int'(vn_col) >= C - R)
        chk(rows_b > int'(vn_col) - (C - R), "R5 parity column dependency", rows_b, int'(vn_col) - (C - R) + 1);
      else
        chk(rows_b == R && !cn_go, "R5 info column dependency", rows_b, R);
    end
    chk(hd_latch == (vn_go && vn_ack), "R7 hard decision latch", hd_latch, vn_go && vn_ack);
    chk(init_go == init_b, "R2 init pulse", init_go, init_b);
    chk(busy == (init_b || run_b), "R2 busy", busy, init_b || run_b);
    chk(dec_done == done_b, "R11 done pulse", dec_done, done_b);
    chk(dec_fail == fail_b, "R10 fail flag", dec_fail, fail_b);
    chk(int'(iter_used) == used_b, "R8 iterations used", iter_used, used_b);

    done_b = 0;
    if (init_b) begin
      init_b = 0; run_b = 1; rows_b = 0; cols_b = 0; iter_b = 1;
      n_c = 0; n_b = 0; n_v = 0;
    end else if (run_b) begin
      hc = ec && cn_ack;
      hv = ev && vn_ack;
      if (ec && !ev) n_c++;
      if (ec && ev)  n_b++;
      if (!ec && ev) n_v++;
      if (hc) rows_b++;
      if (hv) cols_b++;
      if (cols_b == C) begin
        if (stall == 0) begin
          chk(n_c == 1, "R6 check-only cycles", n_c, 1);
          chk(n_b == R - 1, "R6 overlapped cycles", n_b, R - 1);
          chk(n_v == C - R + 1, "R6 variable-only cycles", n_v, C - R + 1);
        end
        n_c = 0; n_b = 0; n_v = 0;
        if (parity_ok || iter_b == IM) begin
          run_b = 0; done_b = 1; fail_b = !parity_ok; used_b = iter_b;
          if (stall == 0)
            chk(busy_cyc == 1 + iter_b * (C + 1), "R6 decode length", busy_cyc, 1 + iter_b * (C + 1));
          decodes++;
        end else begin
          iter_b++; rows_b = 0; cols_b = 0;   // R9 restart at row 0, no init
        end
      end
    end else if (dec_start) begin
      init_b = 1; busy_cyc = 0;
    end
  end

  task automatic run_decode(input int pa, input int st, input bit mid);
    int d0, exp_it;
    d0 = decodes;
    pass_at = pa; stall = st;
    @(posedge clk); #1 dec_start = 1'b1;
    @(posedge clk); #1 dec_start = 1'b0;
    if (mid) begin
      repeat (5) @(posedge clk);
      #1 dec_start = 1'b1;                // R2 start while busy is ignored
      @(posedge clk); #1 dec_start = 1'b0;
    end
    wait (decodes != d0);
    repeat (3) @(posedge clk);
    #1;
    exp_it = (pa < IM) ? pa : IM;
    chk(int'(iter_used) == exp_it, "R8 iterations after decode", iter_used, exp_it);
    chk(dec_fail == (pa > IM), "R10 fail after decode", dec_fail, pa > IM);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !dec_done && !dec_fail && !init_go, "R1 reset flags", busy, 0);
    chk(!cn_go && !vn_go && !hd_latch, "R1 reset triggers", cn_go | vn_go, 0);
    chk(iter_used == 0, "R1 reset iterations", iter_used, 0);
    @(posedge clk); #1 rst_n = 1'b1;
    mon_en = 1;
    repeat (2) @(posedge clk);
    for (int pa = 1; pa <= IM + 1; pa++)
      for (int st = 0; st < 4; st++)
        run_decode(pa, st, 1'b0);
    run_decode(2, 0, 1'b1);
    run_decode(IM + 1, 3, 1'b1);
    repeat (5) @(posedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule